// File: doc/BRIEF.md
# Converter SYNC Pulse Sequencer

This block sits in an FPGA next to a group of delta-sigma converters that share one master clock and one synchronisation line. It divides the fast reference clock by a fixed ratio to produce the converter master clock. On request it then drives the shared SYNC line through a low-then-high pattern, which realigns every converter at once. The request is honoured only after an external serial-port sequencer reports that converter setup is complete.

Converters that capture SYNC on the rising master-clock edge can miss an edge that arrives close to that capture point. Every SYNC transition is therefore launched on the same reference edge that drives the master clock low. This places each SYNC edge half a master period away from capture. Each level is held for a programmable number of master periods, with a lower bound. A retry mode emits low-high-low-high, which gives a converter that missed the first rising edge a second one. A single output drives all converters. After the final rising edge, SYNC stays high until the next sequence.

Top module: `sync_pulse_sequencer`

## Requirements
- R1: `mclk_out` is the reference clock divided by DIV (default 4). It is high for DIV/2 reference cycles and low for DIV/2. Its first rise comes at the third reference edge after `rst_n` is released.
- R2: `sync_out` changes only at a reference edge where `mclk_out` goes from 1 to 0.
- R3: Each level of a sequence, except the final high level, lasts exactly W master periods (W×DIV reference cycles). For `width_cfg` values 2 to 15, W equals `width_cfg`.
- R4: A `width_cfg` of 1 gives W=2, the minimum level width. A `width_cfg` of 0 gives W=4, the default width.
- R5: When `retry_mode`=0, a sequence drives SYNC low for W periods and then high. SYNC then stays high.
- R6: When `retry_mode`=1, a sequence drives SYNC low, high and low for W periods each, and then high. SYNC then stays high.
- R7: A `start_req` is accepted only when the block is idle (`busy`=0) and `cfg_done`=1. Any other request has no effect on `sync_out`, `busy` or `done`.
- R8: `busy` rises at the edge that accepts a request. It stays high until one cycle after `done`.
- R9: `done` is a single-cycle pulse. It rises at the same edge that launches the final SYNC rising edge, and `busy` is high while `done` is high.
- R10: During reset and right after it, `sync_out`, `mclk_out`, `busy` and `done` are all 0.
- R11: After a request is accepted, the first SYNC action happens at the next master-clock falling edge. That action drives SYNC low, which is a falling edge if SYNC was high and no change if it was low.
- R12: `width_cfg` and `retry_mode` are sampled when a request is accepted. Changing them during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_done | input | 1 | High when converter setup is complete |
| start_req | input | 1 | Request to run one SYNC sequence |
| retry_mode | input | 1 | 0: single rising edge, 1: double toggle |
| width_cfg | input | LVL_W (4) | Level width in master periods (0 selects the default, 1 is raised to the minimum) |
| mclk_out | output | 1 | Converter master clock |
| sync_out | output | 1 | Shared SYNC line to all converters |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the final rising edge is launched |

## Verification
The bench builds the block with DIV=4 and a 4-bit width field. This keeps a full sequence at the widest code (15 periods per level, four levels) to a few hundred reference cycles. Every width code, including the clamped values 0 and 1, can be driven within a short run. A reference model steps the divider phase and the SYNC sequence on every edge. The bench also measures the distance between consecutive SYNC edges, so width, pattern and edge placement are checked against values derived from the requirements. Requests are made while busy, while setup is incomplete, and with the width and mode inputs changed mid-sequence.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;

  // Effective level width: zero picks the default, small values are raised.
  function automatic int unsigned eff_level(input int unsigned code,
                                            input int unsigned min_lvl,
                                            input int unsigned dflt_lvl);
    if (code == 0)            return dflt_lvl;
    else if (code < min_lvl)  return min_lvl;
    else                      return code;
  endfunction

endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shreg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = shreg_q[STAGES-1];

endmodule

// File: rtl/sps_mclk_div.sv
module sps_mclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mclk,
  output logic fall_tick
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mclk_d;

  always_comb begin
    if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
    mclk_d = (cnt_d < CW'(HALF));
  end

  // True during the reference cycle whose closing edge drops mclk.
  assign fall_tick = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(DIV - 1);
      mclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mclk  <= mclk_d;
    end
  end

endmodule

// File: rtl/sps_seq_fsm.sv
module sps_seq_fsm
  import sps_pkg::*;
#(
  parameter int LVL_W         = 4,
  parameter int MIN_LEVEL     = 2,
  parameter int DEFAULT_LEVEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_tick,
  input  logic             start_req,
  input  logic             cfg_done,
  input  logic             retry_mode,
  input  logic [LVL_W-1:0] width_cfg,
  output logic             sync_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int EDGE_W = 2;

  seq_state_e        st_q, st_d;
  logic              sync_q, sync_d;
  logic [LVL_W-1:0]  hold_q, hold_d;
  logic [LVL_W-1:0]  wid_q, wid_d;
  logic [EDGE_W-1:0] left_q, left_d;
  logic              accept, load_en, tick_en;

  assign accept  = (st_q == SEQ_IDLE) && start_req && cfg_done;
  assign load_en = accept;
  assign tick_en = fall_tick && ((st_q == SEQ_ARM) || (st_q == SEQ_RUN));

  always_comb begin
    st_d   = st_q;
    sync_d = sync_q;
    hold_d = hold_q;
    wid_d  = wid_q;
    left_d = left_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          st_d   = SEQ_ARM;
          wid_d  = LVL_W'(eff_level(int'(width_cfg), MIN_LEVEL, DEFAULT_LEVEL));
          left_d = retry_mode ? EDGE_W'(3) : EDGE_W'(1);
        end
      end
      SEQ_ARM: begin
        if (fall_tick) begin
          sync_d = 1'b0;
          hold_d = LVL_W'(1);
          st_d   = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (fall_tick) begin
          if (hold_q == wid_q) begin
            sync_d = ~sync_q;
            hold_d = LVL_W'(1);
            left_d = left_q - 1'b1;
            if (left_q == EDGE_W'(1)) st_d = SEQ_DONE;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
      end
      SEQ_DONE: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      sync_q <= 1'b0;
      hold_q <= '0;
      wid_q  <= '0;
      left_q <= '0;
    end else begin
      st_q <= st_d;
      if (tick_en) begin
        sync_q <= sync_d;
        hold_q <= hold_d;
      end
      if (load_en || tick_en) left_q <= left_d;
      if (load_en)            wid_q  <= wid_d;
    end
  end

  assign sync_o = sync_q;
  assign busy_o = (st_q != SEQ_IDLE);
  assign done_o = (st_q == SEQ_DONE);

endmodule

// File: rtl/sync_pulse_sequencer.sv
module sync_pulse_sequencer #(
  parameter int DIV           = 4,
  parameter int LVL_W         = 4,
  parameter int MIN_LEVEL     = 2,
  parameter int DEFAULT_LEVEL = 4,
  parameter int RST_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic             start_req,
  input  logic             retry_mode,
  input  logic [LVL_W-1:0] width_cfg,
  output logic             mclk_out,
  output logic             sync_out,
  output logic             busy,
  output logic             done
);

  logic rst_n_int;
  logic fall_tick;

  sps_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sps_mclk_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mclk      (mclk_out),
    .fall_tick (fall_tick)
  );

  sps_seq_fsm #(
    .LVL_W         (LVL_W),
    .MIN_LEVEL     (MIN_LEVEL),
    .DEFAULT_LEVEL (DEFAULT_LEVEL)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .fall_tick  (fall_tick),
    .start_req  (start_req),
    .cfg_done   (cfg_done),
    .retry_mode (retry_mode),
    .width_cfg  (width_cfg),
    .sync_o     (sync_out),
    .busy_o     (busy),
    .done_o     (done)
  );

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int DIV       = 4,
  parameter int MIN_LEVEL = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_done,
  input logic mclk_out,
  input logic sync_out,
  input logic busy,
  input logic done
);

  localparam logic [15:0] MIN_RUN = 16'(MIN_LEVEL * DIV);

  logic        prev_q;
  logic [15:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      len_q  <= '1;
    end else begin
      prev_q <= sync_out;
      if (sync_out != prev_q)  len_q <= 16'd1;
      else if (len_q != '1)    len_q <= len_q + 16'd1;
    end
  end

  // R1: master clock holds each level for at least two reference cycles
  p_mclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_out) |=> mclk_out);
  p_mclk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_out) |=> !mclk_out);

  // R2: SYNC moves only together with a master-clock fall
  p_sync_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out != $past(sync_out)) |-> ($past(mclk_out) && !mclk_out));

  // R3: no SYNC level shorter than the minimum width
  p_min_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out != prev_q) |-> (len_q >= MIN_RUN));

  // R7: idle with setup incomplete stays idle
  p_no_start_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_done) |=> !busy);

  // R7: SYNC is quiet while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sync_out));

  // R9: done is one cycle wide, with SYNC high and busy set
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sync_out && busy));

endmodule

bind sync_pulse_sequencer sps_checker #(.DIV(DIV), .MIN_LEVEL(MIN_LEVEL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_done (cfg_done),
  .mclk_out (mclk_out),
  .sync_out (sync_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/sync_pulse_sequencer_tb.sv
module sync_pulse_sequencer_tb;

  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int LVL_W = 4;
  localparam int WDOG  = 150000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_done;
  logic             start_req;
  logic             retry_mode;
  logic [LVL_W-1:0] width_cfg;
  logic             mclk_out, sync_out, busy, done;

  always #10 clk = ~clk;

  sync_pulse_sequencer #(.DIV(DIV), .LVL_W(LVL_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .start_req  (start_req),
    .retry_mode (retry_mode),
    .width_cfg  (width_cfg),
    .mclk_out   (mclk_out),
    .sync_out   (sync_out),
    .busy       (busy),
    .done       (done)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_rel;         // edges seen since reset release
  int  m_phase;       // divider phase 0..DIV-1
  int  m_state;       // 0 idle, 1 armed, 2 running, 3 done
  int  m_w, m_hold;
  int  m_levels[$];
  bit  e_mclk, e_sync, e_busy, e_done;

  function automatic int width_of(input int code);
    if (code == 0) return 4;
    if (code < 2)  return 2;
    return code;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WDOG);
      report();
    end
    if (!rst_n) begin
      m_rel = 0; m_phase = DIV - 1; m_state = 0; m_hold = 0; m_w = 0;
      m_levels.delete();
      e_mclk = 0; e_sync = 0; e_busy = 0; e_done = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit falling;
      falling = (m_phase == HALF - 1);
      m_phase = (m_phase + 1) % DIV;
      e_mclk  = (m_phase < HALF);
      e_done  = 0;
      case (m_state)
        0: if (start_req && cfg_done) begin
             m_w = width_of(int'(width_cfg));
             m_levels.delete();
             if (retry_mode) begin
               m_levels.push_back(1); m_levels.push_back(0); m_levels.push_back(1);
             end else m_levels.push_back(1);
             m_state = 1;
           end
        1: if (falling) begin e_sync = 0; m_hold = 1; m_state = 2; end
        2: if (falling) begin
             if (m_hold == m_w) begin
               e_sync = m_levels.pop_front() != 0;
               m_hold = 1;
               if (m_levels.size() == 0) begin m_state = 3; e_done = 1; end
             end else m_hold++;
           end
        default: m_state = 0;
      endcase
      e_busy = (m_state != 0);
    end
  end

  // ---------------- per-cycle compare and edge monitor ----------------
  int  edges[$];
  bit  last_sync = 0;

  always @(negedge clk) begin
    if (cyc >= 1 && !finished) begin
      chk(mclk_out === e_mclk, "R1", "mclk_out", int'(mclk_out), int'(e_mclk));
      chk(sync_out === e_sync, "R2", "sync_out", int'(sync_out), int'(e_sync));
      chk(busy === e_busy, "R8", "busy", int'(busy), int'(e_busy));
      chk(done === e_done, "R9", "done", int'(done), int'(e_done));
    end
    if (sync_out !== last_sync) begin
      edges.push_back(cyc);
      last_sync = sync_out;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, req, "done observed", int'(seen), 1);
  endtask

  task automatic run_seq(input bit rtry, input int code, input string req);
    bit init_hi;
    int n_exp, w;
    init_hi = sync_out;
    w = width_of(code);
    edges.delete();
    retry_mode = rtry;
    width_cfg  = LVL_W'(code);
    pulse_start();
    wait_done(req);
    repeat (3) @(negedge clk);
    n_exp = (init_hi ? 1 : 0) + (rtry ? 3 : 1);
    chk(edges.size() == n_exp, req, "SYNC edge count", edges.size(), n_exp);
    for (int i = 1; i < edges.size(); i++)
      chk(edges[i] - edges[i-1] == w * DIV, req, "level width in ref cycles",
          edges[i] - edges[i-1], w * DIV);
    chk(sync_out == 1'b1, req, "final SYNC level", int'(sync_out), 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_done = 1'b0; start_req = 1'b0;
    retry_mode = 1'b0; width_cfg = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sync_out == 0 && busy == 0 && done == 0 && mclk_out == 0, "R10",
        "outputs during reset", int'({sync_out, busy, done, mclk_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_out == 0 && busy == 0 && mclk_out == 0, "R10",
        "outputs just after release", int'({sync_out, busy, mclk_out}), 0);
    // R1: count master-clock rises over 40 reference cycles
    begin
      int rises = 0;
      bit prev = mclk_out;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mclk_out && !prev) rises++;
        prev = mclk_out;
      end
      chk(rises == 40 / DIV, "R1", "master clock rises in 40 cycles", rises, 40 / DIV);
    end

    // R7: request with setup incomplete is ignored
    edges.delete();
    pulse_start();
    repeat (40) @(negedge clk);
    chk(busy == 0, "R7", "busy after request without cfg_done", int'(busy), 0);
    chk(edges.size() == 0, "R7", "SYNC edges without cfg_done", edges.size(), 0);

    cfg_done = 1'b1;
    run_seq(1'b0, 4, "R5");      // single pattern from low
    run_seq(1'b0, 3, "R5");      // single pattern from high (R11 falling edge)
    run_seq(1'b1, 3, "R6");      // double toggle
    run_seq(1'b0, 0, "R4");      // default width
    run_seq(1'b1, 1, "R4");      // minimum clamp
    run_seq(1'b1, 15, "R3");     // widest code
    run_seq(1'b0, 2, "R3");      // narrowest legal code

    // R12 and R7: inputs changed and request repeated during a sequence
    edges.delete();
    retry_mode = 1'b1; width_cfg = LVL_W'(5);
    pulse_start();
    repeat (7) @(negedge clk);
    retry_mode = 1'b0; width_cfg = LVL_W'(2);
    pulse_start();
    wait_done("R12");
    repeat (3) @(negedge clk);
    chk(edges.size() == 4, "R12", "edges with mid-run changes", edges.size(), 4);
    for (int i = 1; i < edges.size(); i++)
      chk(edges[i] - edges[i-1] == 5 * DIV, "R12", "level width with mid-run changes",
          edges[i] - edges[i-1], 5 * DIV);

    // R11: first action is the next master-clock fall after acceptance
    edges.delete();
    retry_mode = 1'b0; width_cfg = LVL_W'(2);
    pulse_start();
    repeat (DIV + 1) @(negedge clk);
    chk(edges.size() == 1 && sync_out == 0, "R11", "SYNC low within one master period",
        int'(sync_out), 0);
    wait_done("R11");

    repeat (10) @(negedge clk);
    report();
  end

endmodule